// File: doc/BRIEF.md
# Inter-Processor Mailbox Controller

This block passes fixed-size messages between an application processor and a microcontroller. It has two address windows on one 32-bit register port. The buffer window holds one 64-byte slot per channel. Each slot has a handshake word and eight message words. The IPC window holds two 32-bit interrupt vector banks, one for each core. A sender writes the message into a slot and then sets a bit in the peer's raw request register. The peer sees a level interrupt while that bit is both pending and enabled.

The handshake word carries a one-hot progress field and an acknowledge-mode bit. In automatic mode the slot returns to idle by itself once the last message word has been read. In interrupt mode the receiver must write idle back and raise an acknowledge vector itself. Enables can be changed bit by bit through a set register and a clear register, or as a whole vector through a mask register.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, the following are zero: every slot word, every raw bit, every enable bit, both interrupt outputs and `regRdata`.
- R2: In the buffer window (`regWin`=1), channel c's slot starts at byte offset 64*c. The handshake word is at +0x00 and message word i (0..7) is at +0x04+4*i. Each of these nine words reads back the value last written.
- R3: When bit 0 of the handshake word is 1 (automatic acknowledge), a read of message word 7 (+0x20) sets bits 7:4 of the handshake word to 0001 (idle). All other bits are left unchanged.
- R4: When bit 0 of the handshake word is 0 (interrupt acknowledge), a read of message word 7 leaves the handshake word unchanged. Later software writes to it take effect.
- R5: In the IPC window (`regWin`=0), a write to the raw register sets the raw bits written as one and leaves the bits written as zero unchanged. The raw register is at 0x400 for the application-processor bank and 0x420 for the microcontroller bank. Reading the raw register returns the raw vector. Writes to one bank never change the other bank.
- R6: A write to the clear register (0x40C application processor, 0x42C microcontroller) clears the raw bits written as one. Writing all ones clears every pending bit.
- R7: The enable vector can be changed in three ways:
  - A write to the mask register (0x404 / 0x424) replaces the whole enable vector.
  - A write to 0x500 / 0x510 sets the enable bits written as one.
  - A write to 0x504 / 0x514 clears the enable bits written as one.
  The mask register reads the enable vector. The clear, set and disable registers read as zero.
- R8: The status register (0x408 / 0x428) reads the raw vector ANDed with the enable vector. Writes to it are ignored.
- R9: `apIrq` (bank 0x400) and `mcuIrq` (bank 0x420) are level outputs. Each is high exactly while its bank has at least one bit that is both raw-pending and enabled. The change is visible in the cycle after the write that causes it.
- R10: Unmapped offsets read zero and ignore writes. These include IPC offsets outside the list above, slots at or above the channel count, and slot words 9..15.
- R11: `regRdata` takes the read value on the clock edge that accepts the read. It holds that value until the next read, so writes and idle cycles do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regEn | input | 1 | Access request, one cycle per access |
| regWe | input | 1 | 1 = write, 0 = read |
| regWin | input | 1 | Window select: 0 = IPC registers, 1 = slot buffer |
| regAddr | input | 12 | Byte offset within the selected window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| apIrq | output | 1 | Level interrupt to the application processor |
| mcuIrq | output | 1 | Level interrupt to the microcontroller |

## Verification
Every register update, including the automatic return to idle, lands on the edge that accepts the access. A read returns its data on that same edge. The bench therefore drives each access on a falling edge and removes it on the next falling edge. It samples `regRdata` at that second falling edge, one rising edge after the request. Both interrupt outputs are combinational from the bank registers, so the bench checks them at the falling edge right after the write that changes them. The sweeps cover every word of every slot, every bit of the application-processor vector through set, enable and clear, and a cross-bank case on the microcontroller side.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int VEC_W      = 32;
  localparam int SLOT_WORDS = 9;
  localparam int WORD_W     = $clog2(SLOT_WORDS);
  localparam int MAX_CHAN   = 32;
  localparam int SLOT_FLD_W = $clog2(MAX_CHAN);
  localparam int NUM_BANKS  = 2;

  typedef enum logic [2:0] {
    REG_NONE, REG_RAW, REG_MASK, REG_STAT, REG_CLR, REG_ENA, REG_DIS
  } ipcReg_e;

  typedef enum logic [1:0] {RSEL_ZERO, RSEL_IPC, RSEL_BUF} rdSel_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] rawSet;
    logic [NUM_BANKS-1:0] rawClr;
    logic [NUM_BANKS-1:0] enSet;
    logic [NUM_BANKS-1:0] enClr;
    logic [NUM_BANKS-1:0] maskWr;
    logic                 bufWr;
    logic                 lastWordRd;
    logic                 rdStb;
  } ctlStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWe,
  input  logic              regWin,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobe_t        stb,
  output logic [CHAN_W-1:0] slotIdx,
  output logic [WORD_W-1:0] wordIdx,
  output logic              bankSel,
  output ipcReg_e           ipcReg,
  output rdSel_e            rdSel
);
  logic [ADDR_W-1:0]     wordAddr;
  logic [SLOT_FLD_W-1:0] slotField;
  logic                  bufHit;
  logic                  wr;
  logic                  rd;
  logic [1:0]            unusedAddrBits;

  assign unusedAddrBits = regAddr[1:0];
  assign wordAddr  = {regAddr[ADDR_W-1:2], 2'b00};
  assign slotField = regAddr[6 +: SLOT_FLD_W];
  assign wordIdx   = regAddr[2 +: WORD_W];
  assign slotIdx   = slotField[CHAN_W-1:0];
  assign wr = regEn & regWe;
  assign rd = regEn & ~regWe;

  // buffer window decode: slot below channel count, word 0..8
  assign bufHit = !regAddr[ADDR_W-1]
                && ({1'b0, slotField} < (SLOT_FLD_W+1)'(NUM_CHAN))
                && (wordIdx < WORD_W'(SLOT_WORDS));

  // IPC window decode
  always_comb begin
    bankSel = 1'b0;
    ipcReg  = REG_NONE;
    unique case (wordAddr)
      12'h400: begin bankSel = 1'b0; ipcReg = REG_RAW;  end
      12'h404: begin bankSel = 1'b0; ipcReg = REG_MASK; end
      12'h408: begin bankSel = 1'b0; ipcReg = REG_STAT; end
      12'h40C: begin bankSel = 1'b0; ipcReg = REG_CLR;  end
      12'h420: begin bankSel = 1'b1; ipcReg = REG_RAW;  end
      12'h424: begin bankSel = 1'b1; ipcReg = REG_MASK; end
      12'h428: begin bankSel = 1'b1; ipcReg = REG_STAT; end
      12'h42C: begin bankSel = 1'b1; ipcReg = REG_CLR;  end
      12'h500: begin bankSel = 1'b0; ipcReg = REG_ENA;  end
      12'h504: begin bankSel = 1'b0; ipcReg = REG_DIS;  end
      12'h510: begin bankSel = 1'b1; ipcReg = REG_ENA;  end
      12'h514: begin bankSel = 1'b1; ipcReg = REG_DIS;  end
      default: begin bankSel = 1'b0; ipcReg = REG_NONE; end
    endcase
  end

  always_comb begin
    stb = '0;
    stb.rdStb      = rd;
    stb.bufWr      = wr & regWin & bufHit;
    stb.lastWordRd = rd & regWin & bufHit & (wordIdx == WORD_W'(SLOT_WORDS - 1));
    if (wr && !regWin) begin
      unique case (ipcReg)
        REG_RAW:  stb.rawSet[bankSel] = 1'b1;
        REG_CLR:  stb.rawClr[bankSel] = 1'b1;
        REG_ENA:  stb.enSet[bankSel]  = 1'b1;
        REG_DIS:  stb.enClr[bankSel]  = 1'b1;
        REG_MASK: stb.maskWr[bankSel] = 1'b1;
        default:  ;
      endcase
    end
    if (!regWin && ipcReg != REG_NONE)
      rdSel = RSEL_IPC;
    else if (regWin && bufHit)
      rdSel = RSEL_BUF;
    else
      rdSel = RSEL_ZERO;
  end

  // R10: at most one state target per access; unmapped writes reach none
  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rawSet, stb.rawClr, stb.enSet, stb.enClr, stb.maskWr, stb.bufWr}));
  assert_unmapped_inert_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wr && rdSel == RSEL_ZERO) |->
      ({stb.rawSet, stb.rawClr, stb.enSet, stb.enClr, stb.maskWr, stb.bufWr} == '0));
endmodule

// File: rtl/mbox_irq_bank.sv
module mbox_irq_bank
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawSet,
  input  logic             rawClr,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             maskWr,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] raw,
  output logic [VEC_W-1:0] en,
  output logic [VEC_W-1:0] stat,
  output logic             irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      raw <= '0;
      en  <= '0;
    end else begin
      if (rawSet) raw <= raw | wdata;
      else if (rawClr) raw <= raw & ~wdata;
      if (maskWr) en <= wdata;
      else if (enSet) en <= en | wdata;
      else if (enClr) en <= en & ~wdata;
    end
  end

  assign stat = raw & en;
  assign irq  = |stat;

  assert_raw_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    rawSet |=> ((raw & $past(wdata)) == $past(wdata)));
  assert_raw_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!rawSet && !rawClr) |=> $stable(raw));
  assert_raw_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    rawClr |=> ((raw & $past(wdata)) == '0));
  assert_en_disable_R7: assert property (@(posedge clk) disable iff (!rstN)
    enClr |=> ((en & $past(wdata)) == '0));
  assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!enSet && !enClr && !maskWr) |=> $stable(en));
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [CHAN_W-1:0] slotIdx,
  input  logic [WORD_W-1:0] wordIdx,
  input  logic              bankSel,
  input  ipcReg_e           ipcReg,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              apIrq,
  output logic              mcuIrq
);
  logic [DATA_W-1:0] slotMem [NUM_CHAN][SLOT_WORDS];
  logic [VEC_W-1:0]  rawV  [NUM_BANKS];
  logic [VEC_W-1:0]  enV   [NUM_BANKS];
  logic [VEC_W-1:0]  statV [NUM_BANKS];
  logic [NUM_BANKS-1:0] irqV;
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] curHandshake;
  logic              autoMode;

  assign curHandshake = slotMem[slotIdx][0];
  assign autoMode     = curHandshake[0];

  // slot storage with automatic return to idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CHAN; c++)
        for (int w = 0; w < SLOT_WORDS; w++)
          slotMem[c][w] <= '0;
    end else if (stb.bufWr) begin
      slotMem[slotIdx][wordIdx] <= wdata;
    end else if (stb.lastWordRd && autoMode) begin
      slotMem[slotIdx][0][7:4] <= 4'h1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    mbox_irq_bank u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .rawSet (stb.rawSet[b]),
      .rawClr (stb.rawClr[b]),
      .enSet  (stb.enSet[b]),
      .enClr  (stb.enClr[b]),
      .maskWr (stb.maskWr[b]),
      .wdata  (wdata),
      .raw    (rawV[b]),
      .en     (enV[b]),
      .stat   (statV[b]),
      .irq    (irqV[b])
    );
  end

  assign apIrq  = irqV[0];
  assign mcuIrq = irqV[1];

  always_comb begin
    rdNext = '0;
    unique case (rdSel)
      RSEL_IPC: begin
        unique case (ipcReg)
          REG_RAW:  rdNext = rawV[bankSel];
          REG_MASK: rdNext = enV[bankSel];
          REG_STAT: rdNext = statV[bankSel];
          default:  rdNext = '0;
        endcase
      end
      RSEL_BUF: rdNext = slotMem[slotIdx][wordIdx];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else if (stb.rdStb) rdata <= rdNext;
  end

  assert_auto_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lastWordRd && autoMode) |=> (slotMem[$past(slotIdx)][0][7:4] == 4'h1));
  assert_manual_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lastWordRd && !autoMode) |=> (slotMem[$past(slotIdx)][0] == $past(curHandshake)));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb && rdSel == RSEL_ZERO) |=> (rdata == '0));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStb |=> $stable(rdata));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regEn,
  input  logic        regWe,
  input  logic        regWin,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        apIrq,
  output logic        mcuIrq
);
  localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

  ctlStrobe_t        stb;
  logic [CHAN_W-1:0] slotIdx;
  logic [WORD_W-1:0] wordIdx;
  logic              bankSel;
  ipcReg_e           ipcReg;
  rdSel_e            rdSel;

  mbox_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regEn   (regEn),
    .regWe   (regWe),
    .regWin  (regWin),
    .regAddr (regAddr),
    .stb     (stb),
    .slotIdx (slotIdx),
    .wordIdx (wordIdx),
    .bankSel (bankSel),
    .ipcReg  (ipcReg),
    .rdSel   (rdSel)
  );

  mbox_datapath #(.NUM_CHAN(NUM_CHAN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .slotIdx (slotIdx),
    .wordIdx (wordIdx),
    .bankSel (bankSel),
    .ipcReg  (ipcReg),
    .rdSel   (rdSel),
    .wdata   (regWdata),
    .rdata   (regRdata),
    .apIrq   (apIrq),
    .mcuIrq  (mcuIrq)
  );
endmodule

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regEn = 1'b0;
  logic        regWe = 1'b0;
  logic        regWin = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        apIrq;
  logic        mcuIrq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expSlot [NCH][9];

  ipc_mailbox #(.NUM_CHAN(NCH)) u_ipc_mailbox (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWe(regWe), .regWin(regWin),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .apIrq(apIrq), .mcuIrq(mcuIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic win, input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    regEn = 1'b1; regWe = 1'b1; regWin = win; regAddr = addr; regWdata = data;
    @(negedge clk);
    regEn = 1'b0; regWe = 1'b0;
  endtask

  task automatic busRead(input logic win, input logic [11:0] addr, output logic [31:0] data);
    @(negedge clk);
    regEn = 1'b1; regWe = 1'b0; regWin = win; regAddr = addr;
    @(negedge clk);
    regEn = 1'b0;
    data = regRdata;
  endtask

  function automatic logic [11:0] slotAddr(input int c, input int w);
    return 12'(c * 64 + 4 + (w - 1) * 4);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] expRaw;
    logic [31:0] expEn;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 apIrq", {31'b0, apIrq}, 32'h0);
    check("R1 mcuIrq", {31'b0, mcuIrq}, 32'h0);
    check("R1 rdata", regRdata, 32'h0);
    busRead(1'b0, 12'h400, rd); check("R1 ap raw", rd, 32'h0);
    busRead(1'b0, 12'h424, rd); check("R1 mcu mask", rd, 32'h0);
    for (int c = 0; c < NCH; c++) begin
      busRead(1'b1, 12'(c * 64), rd); check("R1 handshake", rd, 32'h0);
    end

    // R2 full slot sweep; low byte of word 0 kept zero so mode is interrupt
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 9; w++) begin
        expSlot[c][w] = 32'hA000_0000 | (c << 16) | (w << 8);
        busWrite(1'b1, slotAddr(c, w), expSlot[c][w]);
      end
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 9; w++) begin
        busRead(1'b1, slotAddr(c, w), rd);
        check("R2 slot word", rd, expSlot[c][w]);
      end

    // R11 read data holds across idle cycles and writes
    busRead(1'b1, slotAddr(2, 4), rd);
    repeat (3) @(negedge clk);
    check("R11 hold idle", regRdata, expSlot[2][4]);
    busWrite(1'b1, slotAddr(6, 1), 32'h1234_5678);
    expSlot[6][1] = 32'h1234_5678;
    check("R11 hold write", regRdata, expSlot[2][4]);

    // R3 automatic acknowledge: transmitting (0x2) + auto bit
    busWrite(1'b1, slotAddr(3, 0), 32'hC000_0021);
    busRead(1'b1, slotAddr(3, 7), rd); check("R3 word6 no ack", rd, expSlot[3][7]);
    busRead(1'b1, slotAddr(3, 0), rd); check("R3 before last", rd, 32'hC000_0021);
    busRead(1'b1, slotAddr(3, 8), rd); check("R3 last data", rd, expSlot[3][8]);
    busRead(1'b1, slotAddr(3, 0), rd); check("R3 idle", rd, 32'hC000_0011);

    // R4 interrupt acknowledge: receiving (0x4), manual
    busWrite(1'b1, slotAddr(5, 0), 32'h0000_0040);
    busRead(1'b1, slotAddr(5, 8), rd); check("R4 last data", rd, expSlot[5][8]);
    busRead(1'b1, slotAddr(5, 0), rd); check("R4 unchanged", rd, 32'h0000_0040);
    busWrite(1'b1, slotAddr(5, 0), 32'h0000_0010);
    busRead(1'b1, slotAddr(5, 0), rd); check("R4 sw idle", rd, 32'h0000_0010);

    // R5 bit-by-bit set with enables off: irq stays low (R9)
    expRaw = '0;
    for (int b = 0; b < 32; b++) begin
      busWrite(1'b0, 12'h400, 32'(1) << b);
      expRaw = expRaw | (32'(1) << b);
      busRead(1'b0, 12'h400, rd); check("R5 raw set", rd, expRaw);
      check("R9 masked low", {31'b0, apIrq}, 32'h0);
    end
    busRead(1'b0, 12'h420, rd); check("R5 other bank", rd, 32'h0);
    busRead(1'b0, 12'h408, rd); check("R8 status none", rd, 32'h0);

    // R7/R9 enable each bit
    expEn = '0;
    for (int b = 0; b < 32; b++) begin
      busWrite(1'b0, 12'h500, 32'(1) << b);
      expEn = expEn | (32'(1) << b);
      check("R9 irq high", {31'b0, apIrq}, 32'h1);
      busRead(1'b0, 12'h408, rd); check("R8 status", rd, expRaw & expEn);
    end

    // R6/R9 clear each bit; irq drops only after the last
    for (int b = 0; b < 32; b++) begin
      busWrite(1'b0, 12'h40C, 32'(1) << b);
      expRaw = expRaw & ~(32'(1) << b);
      check("R9 irq level", {31'b0, apIrq}, {31'b0, (expRaw & expEn) != 0});
      busRead(1'b0, 12'h400, rd); check("R6 raw clear", rd, expRaw);
    end

    // R6 all-ones clear
    busWrite(1'b0, 12'h400, 32'h5A5A_00F3);
    busWrite(1'b0, 12'h40C, 32'hFFFF_FFFF);
    busRead(1'b0, 12'h400, rd); check("R6 clear all", rd, 32'h0);
    check("R9 low after clear", {31'b0, apIrq}, 32'h0);

    // R7 mask / set / clear interplay
    busWrite(1'b0, 12'h404, 32'h0000_00F0);
    busRead(1'b0, 12'h404, rd); check("R7 mask write", rd, 32'h0000_00F0);
    busWrite(1'b0, 12'h500, 32'h0000_000F);
    busRead(1'b0, 12'h404, rd); check("R7 enable set", rd, 32'h0000_00FF);
    busWrite(1'b0, 12'h504, 32'h0000_0030);
    busRead(1'b0, 12'h404, rd); check("R7 disable", rd, 32'h0000_00CF);
    busRead(1'b0, 12'h500, rd); check("R7 set reg reads zero", rd, 32'h0);
    busWrite(1'b0, 12'h404, 32'h0);
    busRead(1'b0, 12'h404, rd); check("R7 mask zero", rd, 32'h0);

    // R5/R9 microcontroller bank
    busWrite(1'b0, 12'h420, 32'h0000_0800);
    busWrite(1'b0, 12'h510, 32'h0000_0800);
    check("R9 mcu irq", {31'b0, mcuIrq}, 32'h1);
    check("R9 ap quiet", {31'b0, apIrq}, 32'h0);
    busRead(1'b0, 12'h400, rd); check("R5 ap untouched", rd, 32'h0);
    busWrite(1'b0, 12'h514, 32'h0000_0800);
    check("R9 mcu disabled", {31'b0, mcuIrq}, 32'h0);
    busRead(1'b0, 12'h420, rd); check("R7 raw kept", rd, 32'h0000_0800);

    // R8 status is read-only
    busWrite(1'b0, 12'h400, 32'h3);
    busWrite(1'b0, 12'h404, 32'h1);
    busWrite(1'b0, 12'h408, 32'hFFFF_FFFF);
    busRead(1'b0, 12'h408, rd); check("R8 status ro", rd, 32'h1);
    busRead(1'b0, 12'h400, rd); check("R8 raw intact", rd, 32'h3);

    // R10 unmapped offsets
    busWrite(1'b0, 12'h100, 32'hFFFF_FFFF);
    busRead(1'b0, 12'h100, rd); check("R10 ipc hole", rd, 32'h0);
    busRead(1'b0, 12'h404, rd); check("R10 mask intact", rd, 32'h1);
    busRead(1'b0, 12'h40C, rd); check("R10 clear reads zero", rd, 32'h0);
    busWrite(1'b1, 12'(NCH * 64 + 4), 32'hDEAD_BEEF);
    busRead(1'b1, 12'(NCH * 64 + 4), rd); check("R10 slot beyond count", rd, 32'h0);
    busRead(1'b1, slotAddr(0, 1), rd); check("R10 no alias", rd, expSlot[0][1]);
    busWrite(1'b1, 12'h024, 32'hDEAD_BEEF);
    busRead(1'b1, 12'h024, rd); check("R10 word 9", rd, 32'h0);
    busRead(1'b1, 12'h028, rd); check("R10 word 10", rd, 32'h0);
    busRead(1'b1, 12'h800, rd); check("R10 upper buffer", rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule